// File: doc/BRIEF.md
# Radix-512 Divider Cycle Controller

This block sequences one radix-512 division through a fixed ten-cycle schedule. A start pulse accepted while the controller is idle launches the schedule. In each cycle the controller drives the control signals of the divider datapath. These are the select of the operand multiplexer feeding the recoder, and the divert select that chooses between the live recoder output and the registered recoded operand. They also include the load enables of the operand, scaled-divisor, residual, recoded-operand and quotient-side (z) registers, and the input-isolation enable of the carry-propagate adder. A one-cycle done pulse follows the last cycle.

Each enable is high only in the cycles where its register really changes. The carry-propagate adder enable is high only in its two use cycles. In every other cycle the adder inputs are held at a constant value. Because the divert select is low for the first two cycles, the live recoded scaling factor reaches the multiply-add in cycle 2. The recoded-operand register can then be used from cycle 3 on, and the schedule needs no extra initialization cycle. The datapath itself sits outside this block.

Top module: `div512_seq_ctrl`

## Requirements
- R1: After reset and while idle, busy_o, done_o and every select and enable output are 0.
- R2: A start_i sampled high at a rising edge while idle makes cycle 1 begin after that edge. busy_o is then high for exactly 10 consecutive cycles, numbered 1 to 10.
- R3: start_i is ignored while busy_o is high: it neither restarts nor lengthens the running schedule.
- R4: done_o is high for exactly one cycle, the cycle right after cycle 10, and busy_o is low in that cycle. A start_i in that cycle is accepted.
- R5: divert_o is 0 in cycles 1 and 2 and 1 in cycles 3 to 10.
- R6: op_sel_o is 0 (pass divisor) in cycle 1, 1 (pass negated scaling factor) in cycle 2, and 2 (pass digit estimate) in cycles 3 to 10.
- R7: op_en_o is high only in cycle 1. m_en_o is high only in cycle 2, so it is high once per division.
- R8: z_en_o is high in cycles 3, 4 and 10 only, so it is high three times per division.
- R9: w_en_o and r_en_o are high in cycles 2 to 9 only.
- R10: cpa_en_o is high in cycles 3 and 10 only. The adder inputs are isolated in all other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a division |
| busy_o | output | 1 | A schedule is running |
| done_o | output | 1 | One-cycle pulse after the last cycle |
| op_sel_o | output | 2 | Operand multiplexer select: 0 divisor, 1 negated scaling factor, 2 digit estimate |
| divert_o | output | 1 | 1 selects the recoded-operand register, 0 selects the live recoder output |
| op_en_o | output | 1 | Operand register load enable |
| m_en_o | output | 1 | Scaling-factor register load enable |
| w_en_o | output | 1 | Residual register load enable |
| r_en_o | output | 1 | Recoded-operand register load enable |
| z_en_o | output | 1 | z register load enable |
| cpa_en_o | output | 1 | Carry-propagate adder input enable |

## Verification
A single isolated start pulse shows the clean ten-cycle pattern, and every output is compared cycle by cycle against a golden schedule that the bench derives from the cycle numbers above. Holding start_i high for many cycles separates a controller that ignores start while busy from one that restarts or stretches the schedule. It also shows that a start in the done cycle is accepted. A pseudo-random start pattern over several hundred cycles mixes mid-schedule pulses, pulses in the done cycle and idle gaps. This catches errors in the cycle count, in the done timing and in any single enable position.

// File: rtl/div512_ctrl_pkg.sv
package div512_ctrl_pkg;
  typedef enum logic [1:0] {
    SEL_DIVISOR = 2'd0,
    SEL_NEG_M   = 2'd1,
    SEL_EST     = 2'd2
  } op_sel_e;

  typedef struct packed {
    op_sel_e op_sel;
    logic    divert;
    logic    op_en;
    logic    m_en;
    logic    w_en;
    logic    r_en;
    logic    z_en;
    logic    cpa_en;
  } ctrl_t;
endpackage

// File: rtl/div512_cycle_cnt.sv
module div512_cycle_cnt #(
  parameter int NUM_CYCLES = 10,
  localparam int CW = $clog2(NUM_CYCLES + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic [CW-1:0] cyc_o,
  output logic          done_o
);
  localparam logic [CW-1:0] LAST = CW'(NUM_CYCLES);

  logic [CW-1:0] cyc_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= (cyc_q == LAST);
      if (cyc_q == '0) cyc_q <= start_i ? CW'(1) : '0;
      else if (cyc_q == LAST) cyc_q <= '0;
      else cyc_q <= cyc_q + CW'(1);
    end
  end

  assign cyc_o  = cyc_q;
  assign done_o = done_q;

  a_r2_start_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cyc_q == '0) |=> (cyc_q == CW'(1)));
  a_r3_busy_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q != '0 && cyc_q != LAST) |=> (cyc_q == $past(cyc_q) + CW'(1)));
  a_r4_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r4_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (cyc_q == '0 || cyc_q == CW'(1)));
endmodule

// File: rtl/div512_ctrl_decode.sv
module div512_ctrl_decode
  import div512_ctrl_pkg::*;
#(
  parameter int NUM_CYCLES  = 10,
  parameter int SCALE_CYC   = 2,
  parameter int ASSIM_CYC   = 3,
  localparam int CW = $clog2(NUM_CYCLES + 1)
) (
  input  logic [CW-1:0] cyc_i,
  output ctrl_t         ctrl_o
);
  localparam int FIRST_ITER = ASSIM_CYC + 1;

  int c;
  always_comb begin
    c = int'(cyc_i);
    ctrl_o        = '0;
    ctrl_o.op_sel = SEL_DIVISOR;
    if (c != 0) begin
      if (c == SCALE_CYC)     ctrl_o.op_sel = SEL_NEG_M;
      else if (c > SCALE_CYC) ctrl_o.op_sel = SEL_EST;
      ctrl_o.divert = (c > SCALE_CYC);
      ctrl_o.op_en  = (c == 1);
      ctrl_o.m_en   = (c == SCALE_CYC);
      ctrl_o.w_en   = (c >= SCALE_CYC) && (c < NUM_CYCLES);
      ctrl_o.r_en   = (c >= SCALE_CYC) && (c < NUM_CYCLES);
      // z: assimilated value, first iteration update, final result
      ctrl_o.z_en   = (c == ASSIM_CYC) || (c == FIRST_ITER) || (c == NUM_CYCLES);
      // adder used to assimilate z and for the final sign/zero test
      ctrl_o.cpa_en = (c == ASSIM_CYC) || (c == NUM_CYCLES);
    end
  end

  always_comb begin
    a_r10_cpa_implies_z: assert (!ctrl_o.cpa_en || ctrl_o.z_en);
    a_r7_single_load: assert ($onehot0({ctrl_o.op_en, ctrl_o.m_en, ctrl_o.cpa_en}));
  end
endmodule

// File: rtl/div512_seq_ctrl.sv
module div512_seq_ctrl
  import div512_ctrl_pkg::*;
#(
  parameter int NUM_CYCLES = 10,
  parameter int SCALE_CYC  = 2,
  parameter int ASSIM_CYC  = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [1:0] op_sel_o,
  output logic       divert_o,
  output logic       op_en_o,
  output logic       m_en_o,
  output logic       w_en_o,
  output logic       r_en_o,
  output logic       z_en_o,
  output logic       cpa_en_o
);
  localparam int CW = $clog2(NUM_CYCLES + 1);

  logic [CW-1:0] cyc;
  ctrl_t         ctrl;

  div512_cycle_cnt #(.NUM_CYCLES(NUM_CYCLES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .cyc_o  (cyc),
    .done_o (done_o)
  );

  div512_ctrl_decode #(
    .NUM_CYCLES(NUM_CYCLES),
    .SCALE_CYC (SCALE_CYC),
    .ASSIM_CYC (ASSIM_CYC)
  ) u_dec (
    .cyc_i (cyc),
    .ctrl_o(ctrl)
  );

  assign busy_o   = (cyc != '0);
  assign op_sel_o = ctrl.op_sel;
  assign divert_o = ctrl.divert;
  assign op_en_o  = ctrl.op_en;
  assign m_en_o   = ctrl.m_en;
  assign w_en_o   = ctrl.w_en;
  assign r_en_o   = ctrl.r_en;
  assign z_en_o   = ctrl.z_en;
  assign cpa_en_o = ctrl.cpa_en;

  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(divert_o || op_en_o || m_en_o || w_en_o || r_en_o || z_en_o || cpa_en_o));
  a_r5_divert_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (divert_o && !cpa_en_o) |=> divert_o);
  a_r7_op_then_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_en_o |=> m_en_o);
  a_r9_w_follows_m: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_en_o |-> (w_en_o && r_en_o && !divert_o));
  a_r4_done_after_cpa: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(cpa_en_o));
endmodule

// File: tb/div512_seq_ctrl_bench.sv
module div512_seq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, divert, op_en, m_en, w_en, r_en, z_en, cpa_en;
  logic [1:0] op_sel;
  int checks = 0, failures = 0;
  int k = 0;          // expected cycle number, 0 = idle
  logic exp_done = 1'b0;
  int done_seen = 0, exp_done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  div512_seq_ctrl u_div512_seq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .op_sel_o(op_sel), .divert_o(divert), .op_en_o(op_en), .m_en_o(m_en),
    .w_en_o(w_en), .r_en_o(r_en), .z_en_o(z_en), .cpa_en_o(cpa_en));

  task automatic chk(input string req, input string nm, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s k=%0d actual=%0d expected=%0d", req, nm, k, act, exp);
    end
  endtask

  // compare all outputs with golden schedule for cycle k
  task automatic check_all();
    int s;
    s = (k == 0 || k == 1) ? 0 : (k == 2 ? 1 : 2);
    chk("R2", "busy", int'(busy), int'(k != 0));
    chk("R4", "done", int'(done), int'(exp_done));
    chk("R6", "op_sel", int'(op_sel), s);
    chk("R5", "divert", int'(divert), int'(k >= 3));
    chk("R7", "op_en", int'(op_en), int'(k == 1));
    chk("R7", "m_en", int'(m_en), int'(k == 2));
    chk("R9", "w_en", int'(w_en), int'(k >= 2 && k <= 9));
    chk("R9", "r_en", int'(r_en), int'(k >= 2 && k <= 9));
    chk("R8", "z_en", int'(z_en), int'(k == 3 || k == 4 || k == N));
    chk("R10", "cpa_en", int'(cpa_en), int'(k == 3 || k == N));
  endtask

  // one cycle: set start, advance model at the edge, check at negedge
  task automatic step(input logic st);
    int nk;
    start = st;
    nk = (k == 0) ? (st ? 1 : 0) : (k == N ? 0 : k + 1);
    exp_done = (k == N);
    if (exp_done) exp_done_cnt++;
    @(posedge clk);
    @(negedge clk);
    k = nk;
    if (done) done_seen++;
    check_all();
  endtask

  initial begin
    logic [7:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "busy_rst", int'(busy), 0);
    chk("R1", "outs_rst", int'({done, op_sel, divert, op_en, m_en, w_en, r_en, z_en, cpa_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all();
    // single pulse division
    step(1'b1);
    for (int i = 0; i < 14; i++) step(1'b0);
    // R3 start held high: restarts only after done cycle
    for (int i = 0; i < 40; i++) step(1'b1);
    for (int i = 0; i < 12; i++) step(1'b0);
    // R3 pulses mid-schedule
    step(1'b1);
    for (int i = 0; i < 12; i++) step(i == 3 || i == 8);
    // pseudo-random start pattern
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] & lfsr[2]);
    end
    for (int i = 0; i < 12; i++) step(1'b0);
    chk("R3", "done_count", done_seen, exp_done_cnt);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule